// File: doc/BRIEF.md
# Per-Cell Autonomous Sleep Controller

This block governs the power switch of a single lookup-table cell in a handshake-driven logic fabric. Every cell carries its own copy, so power is gated cell by cell. The controller watches two things. The first is a data-arrival notice from the predecessor cell. The second is the phase of the cell's input token compared with the phase of its output token; when the two differ, a token is in flight inside the cell.

From these inputs it keeps the cell in one of four conditions: active, standby, asleep, or waking from sleep. It drives a registered sleep-enable to the power switch. It also forwards an early arrival notice to the successor cell, so the successor can power up before its data gets there.

Short gaps in traffic leave the cell in standby. Power is cut only after a programmable number of quiet cycles. A restart from sleep holds the ready output low for a programmable number of settling cycles. The clocked model stands in for a self-timed circuit.

Top module: `cell_sleep_ctrl`

## Requirements
- R1: After reset the controller is in standby. `mode` reads 0, `sleep_en` is 0, `ready` is 1 and `wake_next` is 0. The `mode` encoding is standby=0, active=1, waking=2, sleep=3.
- R2: In standby, a phase mismatch (`in_phase` != `out_phase`) moves the controller to active on the next cycle. It stays active for as long as the mismatch lasts.
- R3: In active, the cycle after the two phases match, the controller is back in standby.
- R4: `wake_next` in any cycle equals the OR of the previous cycle's `wake_in` and its phase mismatch.
- R5: In standby, with no wakeup and no mismatch, the controller enters sleep after `idle_limit`+1 consecutive quiet cycles. After `idle_limit` such cycles it is still in standby.
- R6: A `wake_in` pulse during standby restarts the quiet-cycle count from zero.
- R7: If `wake_in` arrives in the same cycle the quiet count reaches `idle_limit`, the controller stays in standby and `sleep_en` stays 0.
- R8: `sleep_en` is 1 exactly while the controller is in sleep. `ready` is 0 in sleep and in waking, and 1 in standby and active.
- R9: In sleep, `wake_in` or a phase mismatch moves the controller to waking on the next cycle.
- R10: Waking lasts `wake_cycles`+1 cycles, then the controller enters active. With `wake_cycles` = 0 it is active one cycle after waking began.
- R11: `idle_limit` = 0 sends a quiet standby cell to sleep after a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_in | input | 1 | Data-arrival notice from the predecessor cell |
| in_phase | input | 1 | Phase of the token at the cell input |
| out_phase | input | 1 | Phase of the token at the cell output |
| idle_limit | input | IDLE_W | Quiet standby cycles allowed before sleep (minus one) |
| wake_cycles | input | WAKE_W | Settling cycles after a restart (minus one) |
| sleep_en | output | 1 | Power-switch off request, high only in sleep |
| ready | output | 1 | Cell powered and usable |
| wake_next | output | 1 | Early arrival notice to the successor cell |
| mode | output | 2 | Current condition: 0 standby, 1 active, 2 waking, 3 sleep |

## Verification
The bench builds the controller with `IDLE_W` = 8 and `WAKE_W` = 3. These narrow widths keep every timeout short enough to walk cycle by cycle. At run time it programs an idle limit of 5 and of 0, and settling counts of 2 and 0. This brings into reach:
- the exact cycle of entry into sleep;
- the count restart caused by a wakeup;
- the tie between a wakeup and an expiring count;
- the zero-length boundaries of both timers.

// File: rtl/csc_pkg.sv
// Package: shared condition encoding for the per-cell sleep controller.
// Assumes: two bits cover all conditions; the encoding is visible on the
// top-level mode port and is relied on by the checker and bench.
package csc_pkg;
    typedef enum logic [1:0] {
        CM_STANDBY = 2'd0,
        CM_ACTIVE  = 2'd1,
        CM_WAKING  = 2'd2,
        CM_SLEEP   = 2'd3
    } cell_mode_t;
endpackage

// File: rtl/csc_phase_watch.sv
// Module: csc_phase_watch
// Compares the token phase at the input and output of the cell. It flags a
// pending token and registers the early notice for the successor cell.
// Assumes: the phase inputs are already synchronous to clk.
module csc_phase_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_in,
    input  logic in_phase,
    input  logic out_phase,
    output logic pending,
    output logic wake_next
);
    // Flag a token in flight whenever the phases disagree.
    always_comb begin
        pending = in_phase ^ out_phase;
    end

    // Forward an arrival notice one cycle after an arrival or a pending token.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_next <= 1'b0;
        else        wake_next <= wake_in | pending;
    end
endmodule

// File: rtl/csc_span_counter.sv
// Module: csc_span_counter
// Saturating up-counter that reports when it equals a run-time limit.
// Assumes: clear has priority over count; the count holds once it hits the limit.
module csc_span_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    // Report the match with the programmed limit.
    always_comb begin
        hit = (cnt == limit);
    end

    // Clear, advance, or hold the span count.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (clr)       cnt <= '0;
        else if (en && !hit) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/csc_mode_fsm.sv
// Module: csc_mode_fsm
// Four-condition state machine for one cell, with registered outputs.
// Assumes: the timer hit flags come from counters that this block clears
// outside their own condition.
module csc_mode_fsm
    import csc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_in,
    input  logic       pending,
    input  logic       idle_hit,
    input  logic       settle_hit,
    output cell_mode_t mode_q,
    output logic       sleep_en,
    output logic       ready
);
    cell_mode_t mode_d;

    // Choose the next condition from the current one and the activity flags.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            CM_STANDBY: begin
                if (pending)       mode_d = CM_ACTIVE;
                else if (wake_in)  mode_d = CM_STANDBY;
                else if (idle_hit) mode_d = CM_SLEEP;
            end
            CM_ACTIVE: begin
                if (!pending) mode_d = CM_STANDBY;
            end
            CM_SLEEP: begin
                if (wake_in || pending) mode_d = CM_WAKING;
            end
            CM_WAKING: begin
                if (settle_hit) mode_d = CM_ACTIVE;
            end
            default: mode_d = CM_STANDBY;
        endcase
    end

    // Register the condition and the outputs derived from the next condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= CM_STANDBY;
            sleep_en <= 1'b0;
            ready    <= 1'b1;
        end else begin
            mode_q   <= mode_d;
            sleep_en <= (mode_d == CM_SLEEP);
            ready    <= (mode_d == CM_STANDBY) || (mode_d == CM_ACTIVE);
        end
    end
endmodule

// File: rtl/cell_sleep_ctrl.sv
// Module: cell_sleep_ctrl
// Top level of the per-cell sleep controller. It ties together the phase
// watcher, the quiet-time counter, the settle counter and the state machine.
// Assumes: one instance per lookup-table cell; limits are static while in use.
module cell_sleep_ctrl
    import csc_pkg::*;
#(
    parameter int IDLE_W = 16,
    parameter int WAKE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_in,
    input  logic              in_phase,
    input  logic              out_phase,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic [WAKE_W-1:0] wake_cycles,
    output logic              sleep_en,
    output logic              ready,
    output logic              wake_next,
    output logic [1:0]        mode
);
    logic       pending;
    logic       idle_hit;
    logic       settle_hit;
    logic       idle_clr;
    logic       idle_en;
    logic       settle_clr;
    logic       settle_en;
    cell_mode_t mode_q;

    csc_phase_watch u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_in   (wake_in),
        .in_phase  (in_phase),
        .out_phase (out_phase),
        .pending   (pending),
        .wake_next (wake_next)
    );

    // Quiet-time counter runs only in standby; a wakeup restarts it.
    always_comb begin
        idle_en    = (mode_q == CM_STANDBY);
        idle_clr   = !idle_en || wake_in;
        settle_en  = (mode_q == CM_WAKING);
        settle_clr = !settle_en;
    end

    csc_span_counter #(.W(IDLE_W)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idle_clr),
        .en    (idle_en),
        .limit (idle_limit),
        .hit   (idle_hit)
    );

    csc_span_counter #(.W(WAKE_W)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (settle_clr),
        .en    (settle_en),
        .limit (wake_cycles),
        .hit   (settle_hit)
    );

    csc_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_in    (wake_in),
        .pending    (pending),
        .idle_hit   (idle_hit),
        .settle_hit (settle_hit),
        .mode_q     (mode_q),
        .sleep_en   (sleep_en),
        .ready      (ready)
    );

    // Expose the condition code on a plain port.
    always_comb begin
        mode = mode_q;
    end
endmodule

// File: rtl/cell_sleep_ctrl_chk.sv
// Module: cell_sleep_ctrl_chk
// Property checker for cell_sleep_ctrl, attached through bind.
// Assumes: mode uses the encoding 0 standby, 1 active, 2 waking, 3 sleep.
module cell_sleep_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wake_in,
    input logic       in_phase,
    input logic       out_phase,
    input logic       sleep_en,
    input logic       ready,
    input logic       wake_next,
    input logic [1:0] mode
);
    // R2
    token_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && (in_phase != out_phase)) |=> (mode == 2'd1));

    // R3
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && (in_phase == out_phase)) |=> (mode == 2'd0));

    // R4
    forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (wake_next == $past(wake_in | (in_phase ^ out_phase))));

    // R7
    tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && wake_in && (in_phase == out_phase)) |=> (mode == 2'd0));

    // R8
    gate_only_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_en |-> (mode == 2'd3 && !ready));

    // R9
    wake_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && (wake_in || (in_phase != out_phase))) |=> (mode == 2'd2));

    // R5
    no_direct_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |=> (mode != 2'd3));
endmodule

bind cell_sleep_ctrl cell_sleep_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake_in   (wake_in),
    .in_phase  (in_phase),
    .out_phase (out_phase),
    .sleep_en  (sleep_en),
    .ready     (ready),
    .wake_next (wake_next),
    .mode      (mode)
);

// File: tb/cell_sleep_ctrl_test.sv
module cell_sleep_ctrl_test;
    localparam int IW = 8;
    localparam int WW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wake_in = 1'b0;
    logic          in_phase = 1'b0;
    logic          out_phase = 1'b0;
    logic [IW-1:0] idle_limit = 8'd5;
    logic [WW-1:0] wake_cycles = 3'd2;
    logic          sleep_en;
    logic          ready;
    logic          wake_next;
    logic [1:0]    mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cell_sleep_ctrl #(.IDLE_W(IW), .WAKE_W(WW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake_in     (wake_in),
        .in_phase    (in_phase),
        .out_phase   (out_phase),
        .idle_limit  (idle_limit),
        .wake_cycles (wake_cycles),
        .sleep_en    (sleep_en),
        .ready       (ready),
        .wake_next   (wake_next),
        .mode        (mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Mode, sleep_en and ready together; ready/sleep_en derive from R8.
    task automatic chk_mode(input string req, input int m);
        chk({req, " mode"}, mode, m);
        chk({req, " sleep_en R8"}, sleep_en, (m == 3) ? 1 : 0);
        chk({req, " ready R8"}, ready, (m == 0 || m == 1) ? 1 : 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wake_in = 0; in_phase = 0; out_phase = 0;
        tick(2);
        rst_n = 1'b1;
        chk_mode("R1 reset", 0);
        chk("R1 wake_next", wake_next, 0);
    endtask

    task automatic t_token();
        in_phase = ~out_phase;
        tick();
        chk_mode("R2 token start", 1);
        chk("R4 forward on pending", wake_next, 1);
        tick(3);
        chk_mode("R2 hold while pending", 1);
        out_phase = in_phase;
        tick();
        chk_mode("R3 drain", 0);
        chk("R4 forward clears", wake_next, 0);
    endtask

    task automatic t_timeout();
        idle_limit = 8'd5;
        tick(5);
        chk_mode("R5 before limit", 0);
        tick();
        chk_mode("R5 enters sleep", 3);
    endtask

    task automatic t_wake_from_sleep();
        wake_cycles = 3'd2;
        wake_in = 1'b1;
        tick();
        wake_in = 1'b0;
        chk_mode("R9 waking", 2);
        chk("R4 forward on wake_in", wake_next, 1);
        tick(2);
        chk_mode("R10 still waking", 2);
        tick();
        chk_mode("R10 active after settle", 1);
        tick();
        chk_mode("R3 back to standby", 0);
    endtask

    task automatic t_restart_count();
        tick(4);
        wake_in = 1'b1;
        tick();
        wake_in = 1'b0;
        chk_mode("R6 wake keeps standby", 0);
        tick(5);
        chk_mode("R6 count restarted", 0);
        tick();
        chk_mode("R6 sleep after restart", 3);
    endtask

    task automatic t_tie();
        wake_cycles = 3'd0;
        wake_in = 1'b1;
        tick();
        wake_in = 1'b0;
        tick();
        chk_mode("R10 zero settle active", 1);
        tick();
        chk_mode("R3 standby again", 0);
        tick(5);
        wake_in = 1'b1;
        tick();
        wake_in = 1'b0;
        chk_mode("R7 wakeup wins tie", 0);
        tick(5);
        chk_mode("R7 count restarted", 0);
    endtask

    task automatic t_phase_wake();
        tick();
        chk_mode("R5 sleep", 3);
        in_phase = ~out_phase;
        tick();
        chk_mode("R9 phase wakes", 2);
        tick();
        chk_mode("R10 active", 1);
        tick(20);
        chk_mode("R2 long token stays active", 1);
        out_phase = in_phase;
        tick();
        chk_mode("R3 drain", 0);
    endtask

    task automatic t_zero_limit();
        idle_limit = 8'd0;
        tick();
        chk_mode("R11 zero limit sleeps", 3);
    endtask

    initial begin
        t_reset();
        t_token();
        t_timeout();
        t_wake_from_sleep();
        t_restart_count();
        t_tie();
        t_phase_wake();
        t_zero_limit();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule